// File: doc/BRIEF.md
# Multi-link readout packet parser

This block walks a stream of 32-bit words holding one detector event and pulls out its framing. It waits for a two-word start marker and decodes the event header that follows. It then emits the packed per-sample lengths one at a time. For each front-end packet it decodes the two header words and unpacks the per-link lengths into a small table. Each link's word budget is handed, in link order, to a downstream channel sequencer.

While a link is being served, the parser stops taking words. The stream then belongs to the sequencer until it pulses `link_done`. After the last link, the parser takes the packet checksum word and passes it on without checking it. It then expects either another packet header or the two-word end marker.

Two conditions raise sticky error flags. A packet header whose version field is not 1 sets one of them, and the parser then throws words away until a new start marker arrives. A broken end marker sets the other.

Top module: `evt_stream_parser`

## Requirements
- R1: After reset, `in_ready` is 1, `link_busy` is 0, every strobe is 0 and both error flags are 0.
- R2: Words are discarded until 0x11111111 is directly followed by 0xBEEF2021; a repeated 0x11111111 keeps the first half matched. The next word is the event header: version bits 31:28, FPGA id bits 27:20, sample count bits 19:16, length bits 15:0. It is reported with one `evt_hdr_stb` pulse.
- R3: Sample lengths follow, two per word: 12 bits at bit 0 for even indices and at bit 16 for odd indices. One `samp_stb` pulse is produced per sample, in index order. A new word is taken only for even indices, so ceil(n/2) words are consumed.
- R4: A packet header word with version 1 (bits 31:28) is decoded as FPGA id 27:20, link count 19:14 and length 11:0, with bits 13:12 ignored. The second word gives bunch id 31:20, read request 19:10 and orbit 9:0. One `pkt_stb` pulse carries all of these fields.
- R5: A packet header with version not equal to 1 sets `err_version`, which stays set until reset. No `pkt_stb` pulse is produced, and every word is discarded until the next start marker pair.
- R6: Link lengths are packed four per word in 8-bit slots at bits 0, 8, 16 and 24, lowest link first. In each slot, bits 5:0 hold the length, bit 7 the ROC-id-OK flag and bit 6 the CDC-OK flag. Each link gets one `link_start` pulse, in link order, carrying its index, length and flags.
- R7: From a `link_start` until `link_done` is seen, `in_ready` is 0 and `link_busy` is 1. A `link_done` pulse outside this state has no effect.
- R8: After the last link, exactly one word is taken as the checksum and reported unchanged with `cksum_stb`. The parser then expects another packet header or the end marker.
- R9: 0xD07E2021 followed by 0x12345678, arriving where a packet header is expected, gives one `evt_end` pulse and returns the parser to the search for a start marker. If any other word follows 0xD07E2021, `err_frame` is set and stays set.
- R10: A sample count of 0 goes straight to the packet header. A link count of 0 goes straight to the checksum word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Parser takes the word this cycle |
| link_done | input | 1 | Sequencer finished the current link |
| link_busy | output | 1 | Stream handed to the sequencer |
| evt_hdr_stb | output | 1 | Event header decoded |
| evt_ver | output | 4 | Event format version |
| evt_fpga | output | 8 | Event FPGA id |
| evt_nsamp | output | 4 | Sample count |
| evt_len | output | 16 | Event length |
| samp_stb | output | 1 | Sample length valid |
| samp_idx | output | 4 | Sample index |
| samp_len | output | 12 | Sample length |
| pkt_stb | output | 1 | Packet header decoded |
| pkt_fpga | output | 8 | Packet FPGA id |
| pkt_nlinks | output | 6 | Link count |
| pkt_len | output | 12 | Packet length |
| pkt_bx | output | 12 | Bunch id |
| pkt_rreq | output | 10 | Read request |
| pkt_orbit | output | 10 | Orbit |
| link_start | output | 1 | Start of a link budget |
| link_idx | output | 6 | Link index |
| link_len | output | 6 | Link word budget |
| link_rid_ok | output | 1 | ROC-id-OK flag of the link |
| link_cdc_ok | output | 1 | CDC-OK flag of the link |
| cksum_stb | output | 1 | Checksum word taken |
| cksum_word | output | 32 | Checksum word, unchecked |
| evt_end | output | 1 | End marker seen |
| err_version | output | 1 | Sticky bad-version flag |
| err_frame | output | 1 | Sticky broken-end-marker flag |

## Verification
The hardest case to reach from the ports is a packet with exactly one link. Here the only link length is written into the table in the same cycle that the first `link_start` must show it. The stimulus therefore sends a one-link packet right after a four-link packet that left a different value in entry 0, so a stale table read shows up as a wrong length.

Recovery after a bad version needs the parser to ignore a whole trailing packet that looks valid and a footer pair. The bench sends exactly that before a fresh event and expects no output from it. The sequencer model holds `link_done` back for several cycles while the driver is already offering the next word, which tests that the stall in R7 really holds the stream.

// File: rtl/evt_stream_parser.sv
module evt_stream_parser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  input  logic        link_done,
  output logic        link_busy,
  output logic        evt_hdr_stb,
  output logic [3:0]  evt_ver,
  output logic [7:0]  evt_fpga,
  output logic [3:0]  evt_nsamp,
  output logic [15:0] evt_len,
  output logic        samp_stb,
  output logic [3:0]  samp_idx,
  output logic [11:0] samp_len,
  output logic        pkt_stb,
  output logic [7:0]  pkt_fpga,
  output logic [5:0]  pkt_nlinks,
  output logic [11:0] pkt_len,
  output logic [11:0] pkt_bx,
  output logic [9:0]  pkt_rreq,
  output logic [9:0]  pkt_orbit,
  output logic        link_start,
  output logic [5:0]  link_idx,
  output logic [5:0]  link_len,
  output logic        link_rid_ok,
  output logic        link_cdc_ok,
  output logic        cksum_stb,
  output logic [31:0] cksum_word,
  output logic        evt_end,
  output logic        err_version,
  output logic        err_frame
);
  localparam logic [31:0] START0 = 32'h1111_1111;
  localparam logic [31:0] START1 = 32'hBEEF_2021;
  localparam logic [31:0] END0   = 32'hD07E_2021;
  localparam logic [31:0] END1   = 32'h1234_5678;

  typedef enum logic [3:0] {S_IDLE, S_MAG2, S_EVH, S_SLEN, S_PK1, S_FT2,
                            S_PK2, S_LLEN, S_LINK, S_CKS} st_t;
  st_t st;
  logic [5:0]  cnt, li;
  logic [31:0] hold;
  logic [7:0]  tbl [64];
  logic [7:0]  slot;
  logic        acc, sstep, lstep;

  assign in_ready = (st == S_IDLE) | (st == S_MAG2) | (st == S_EVH) | (st == S_PK1) |
                    (st == S_FT2) | (st == S_PK2) | (st == S_CKS) |
                    ((st == S_SLEN) & ~cnt[0]) | ((st == S_LLEN) & (cnt[1:0] == 2'd0));
  assign link_busy = (st == S_LINK);
  assign acc   = in_valid & in_ready;
  assign sstep = (st == S_SLEN) & (cnt[0] | acc);
  assign lstep = (st == S_LLEN) & ((cnt[1:0] != 2'd0) | acc);
  assign slot  = (cnt[1:0] == 2'd0) ? in_data[7:0] : hold[{cnt[1:0], 3'b000} +: 8];

  always_ff @(posedge clk)
    if (lstep) tbl[cnt] <= slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; li <= '0; hold <= '0;
      evt_hdr_stb <= 1'b0; evt_ver <= '0; evt_fpga <= '0; evt_nsamp <= '0; evt_len <= '0;
      samp_stb <= 1'b0; samp_idx <= '0; samp_len <= '0;
      pkt_stb <= 1'b0; pkt_fpga <= '0; pkt_nlinks <= '0; pkt_len <= '0;
      pkt_bx <= '0; pkt_rreq <= '0; pkt_orbit <= '0;
      link_start <= 1'b0; link_idx <= '0; link_len <= '0; link_rid_ok <= 1'b0; link_cdc_ok <= 1'b0;
      cksum_stb <= 1'b0; cksum_word <= '0; evt_end <= 1'b0;
      err_version <= 1'b0; err_frame <= 1'b0;
    end else begin
      evt_hdr_stb <= 1'b0; samp_stb <= 1'b0; pkt_stb <= 1'b0;
      link_start <= 1'b0; cksum_stb <= 1'b0; evt_end <= 1'b0;
      case (st)
        S_IDLE: if (acc && in_data == START0) st <= S_MAG2;
        S_MAG2: if (acc) st <= (in_data == START1) ? S_EVH : (in_data == START0) ? S_MAG2 : S_IDLE;
        S_EVH: if (acc) begin
          {evt_ver, evt_fpga, evt_nsamp, evt_len} <= in_data;
          evt_hdr_stb <= 1'b1;
          cnt <= '0;
          st <= (in_data[19:16] == 4'd0) ? S_PK1 : S_SLEN;
        end
        S_SLEN: if (sstep) begin
          samp_stb <= 1'b1;
          samp_idx <= cnt[3:0];
          samp_len <= cnt[0] ? hold[27:16] : in_data[11:0];
          if (!cnt[0]) hold <= in_data;
          cnt <= cnt + 6'd1;
          if (cnt[3:0] == evt_nsamp - 4'd1) st <= S_PK1;
        end
        S_PK1: if (acc) begin
          if (in_data == END0) st <= S_FT2;
          else if (in_data[31:28] != 4'd1) begin
            err_version <= 1'b1;
            st <= S_IDLE;
          end else begin
            pkt_fpga <= in_data[27:20];
            pkt_nlinks <= in_data[19:14];
            pkt_len <= in_data[11:0];
            st <= S_PK2;
          end
        end
        S_FT2: if (acc) begin
          if (in_data == END1) evt_end <= 1'b1;
          else err_frame <= 1'b1;
          st <= S_IDLE;
        end
        S_PK2: if (acc) begin
          {pkt_bx, pkt_rreq, pkt_orbit} <= in_data;
          pkt_stb <= 1'b1;
          cnt <= '0;
          st <= (pkt_nlinks == 6'd0) ? S_CKS : S_LLEN;
        end
        S_LLEN: if (lstep) begin
          if (cnt[1:0] == 2'd0) hold <= in_data;
          cnt <= cnt + 6'd1;
          if (cnt == pkt_nlinks - 6'd1) begin
            st <= S_LINK;
            li <= '0;
            link_start <= 1'b1;
            link_idx <= '0;
            {link_rid_ok, link_cdc_ok, link_len} <= (cnt == 6'd0) ? slot : tbl[0];
          end
        end
        S_LINK: if (link_done) begin
          if (li == pkt_nlinks - 6'd1) st <= S_CKS;
          else begin
            li <= li + 6'd1;
            link_start <= 1'b1;
            link_idx <= li + 6'd1;
            {link_rid_ok, link_cdc_ok, link_len} <= tbl[li + 6'd1];
          end
        end
        S_CKS: if (acc) begin
          cksum_stb <= 1'b1;
          cksum_word <= in_data;
          st <= S_PK1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_stall_in_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_start |-> (!in_ready && link_busy));
  assert_version_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_version |=> err_version);
  assert_frame_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |=> err_frame);
  assert_link_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    link_start |-> (link_idx < pkt_nlinks));
  assert_samp_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb |-> (samp_idx < evt_nsamp));
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_hdr_stb, samp_stb, pkt_stb, link_start, cksum_stb, evt_end}));
  assert_end_after_marker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_end |-> ($past(in_valid) && $past(in_data) == END1));
endmodule

// File: tb/test_evt_stream_parser.sv
module test_evt_stream_parser;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, link_done = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, link_busy, evt_hdr_stb, samp_stb, pkt_stb, link_start, cksum_stb, evt_end;
  logic err_version, err_frame, link_rid_ok, link_cdc_ok;
  logic [3:0] evt_ver, evt_nsamp, samp_idx;
  logic [7:0] evt_fpga, pkt_fpga;
  logic [15:0] evt_len;
  logic [11:0] samp_len, pkt_len, pkt_bx;
  logic [5:0] pkt_nlinks, link_idx, link_len;
  logic [9:0] pkt_rreq, pkt_orbit;
  logic [31:0] cksum_word;
  int total = 0, bad = 0;
  logic [63:0] expq[$];

  always #5 clk = ~clk;

  evt_stream_parser i_evt_stream_parser (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] k);
    case (k)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R6";
      4'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic got(input logic [63:0] a);
    logic [63:0] e;
    if (expq.size() == 0) check(1'b0, {tag(a[63:60]), " unexpected"}, a, 64'd0);
    else begin
      e = expq.pop_front();
      check(a == e, tag(e[63:60]), a, e);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (evt_hdr_stb) got({4'd1, 28'd0, evt_ver, evt_fpga, evt_nsamp, evt_len});
    if (samp_stb)    got({4'd2, 44'd0, samp_idx, samp_len});
    if (pkt_stb)     got({4'd3, 2'd0, pkt_fpga, pkt_nlinks, pkt_len, pkt_bx, pkt_rreq, pkt_orbit});
    if (link_start)  got({4'd4, 46'd0, link_idx, link_rid_ok, link_cdc_ok, link_len});
    if (cksum_stb)   got({4'd5, 28'd0, cksum_word});
    if (evt_end)     got({4'd6, 60'd0});
  end

  // sequencer model: holds each link for a few cycles (R7)
  initial forever begin
    @(negedge clk);
    while (link_start) begin
      repeat (3) begin
        check(!in_ready && link_busy, "R7 stall", {in_ready, link_busy}, 2'b01);
        @(negedge clk);
      end
      link_done = 1'b1;
      @(negedge clk);
      link_done = 1'b0;
    end
  end

  task automatic put(input logic [31:0] w);
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic ev_start(input logic [7:0] f, input logic [3:0] ns, input logic [15:0] ln, input int seed);
    logic [11:0] lo, hi;
    expq.push_back({4'd1, 28'd0, 4'd1, f, ns, ln});
    for (int i = 0; i < ns; i++) expq.push_back({4'd2, 44'd0, 4'(i), 12'(seed + 37 * i)});
    put(32'h1111_1111); put(32'hBEEF_2021); put({4'd1, f, ns, ln});
    for (int k = 0; 2 * k < ns; k++) begin
      lo = 12'(seed + 74 * k);
      hi = (2 * k + 1 < ns) ? 12'(seed + 37 * (2 * k + 1)) : 12'hFFF;
      put({4'hA, hi, 4'h5, lo});
    end
  endtask

  function automatic logic [7:0] slotv(input int j, input int nl, input int seed);
    if (j >= nl) return 8'hEE;
    return {j[0], j[1], 6'(seed + 11 * j)};
  endfunction

  task automatic pkt(input logic [7:0] f, input int nl, input logic [11:0] ln, input logic [11:0] bx,
                     input logic [9:0] rq, input logic [9:0] ob, input int seed);
    expq.push_back({4'd3, 2'd0, f, 6'(nl), ln, bx, rq, ob});
    for (int j = 0; j < nl; j++) expq.push_back({4'd4, 46'd0, 6'(j), slotv(j, nl, seed)});
    expq.push_back({4'd5, 28'd0, 8'hC5, f, 16'(seed)});
    put({4'd1, f, 6'(nl), 2'b11, ln});
    put({bx, rq, ob});
    for (int g = 0; 4 * g < nl; g++)
      put({slotv(4 * g + 3, nl, seed), slotv(4 * g + 2, nl, seed), slotv(4 * g + 1, nl, seed), slotv(4 * g, nl, seed)});
    put({8'hC5, f, 16'(seed)});
  endtask

  task automatic footer();
    expq.push_back({4'd6, 60'd0});
    put(32'hD07E_2021); put(32'h1234_5678);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !link_busy, "R1 ready", {in_ready, link_busy}, 2'b10);
    check({evt_hdr_stb, samp_stb, pkt_stb, link_start, cksum_stb, evt_end} == 0, "R1 strobes", 0, 0);
    check(!err_version && !err_frame, "R1 errors", {err_version, err_frame}, 0);
    // stray words and a stray link_done are ignored (R2, R7)
    link_done = 1'b1; @(negedge clk); link_done = 1'b0;
    put(32'h1234_5678); put(32'hBEEF_2021); put(32'hD07E_2021);
    check(in_ready && !link_busy, "R7 ignored done", {in_ready, link_busy}, 2'b10);
    // repeated first marker word, odd sample count, 5-link and 0-link packets (R2 R3 R6 R10)
    put(32'h1111_1111);
    ev_start(8'h3C, 4'd3, 16'hABCD, 100);
    pkt(8'h3C, 5, 12'h123, 12'hFED, 10'h2AA, 10'h155, 7);
    pkt(8'h3D, 0, 12'h004, 12'h001, 10'h3FF, 10'h000, 9);
    footer();
    // zero samples, 4-link then 1-link (table bypass) packets (R10 R6)
    ev_start(8'h01, 4'd0, 16'h0010, 0);
    pkt(8'h01, 4, 12'hFFF, 12'h800, 10'h001, 10'h200, 21);
    pkt(8'h02, 1, 12'h001, 12'h7FF, 10'h100, 10'h3FE, 50);
    footer();
    // bad version: sticky flag, trailing packet and footer ignored (R5)
    ev_start(8'h10, 4'd2, 16'h0001, 5);
    put({4'd2, 8'h10, 6'd1, 2'b00, 12'h010});
    check(err_version, "R5 set", err_version, 1);
    put(32'h0000_0001); put({4'd1, 8'h10, 6'd1, 2'b00, 12'h010}); put(32'h0); put(32'h3F);
    put(32'hD07E_2021); put(32'h1234_5678);
    repeat (2) @(negedge clk);
    check(expq.size() == 0, "R5 discard", expq.size(), 0);
    ev_start(8'hF0, 4'd15, 16'hFFFF, 4000);
    pkt(8'hF0, 8, 12'h0AA, 12'h055, 10'h0F0, 10'h30F, 33);
    footer();
    check(err_version && !err_frame, "R5 sticky", {err_version, err_frame}, 2'b10);
    // broken end marker (R9)
    ev_start(8'h22, 4'd1, 16'h0002, 77);
    put(32'hD07E_2021); put(32'h0000_0000);
    check(err_frame, "R9 frame error", err_frame, 1);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R8 all items seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule